// File: doc/BRIEF.md
# HDLC Status Register with Carrier-Loss Monitor

This block assembles the one-byte status word that a host polls to service an HDLC controller sitting behind an E1 line interface. Three bits are sticky event flags. They record a finished or failed receive frame, a detected opening flag, and a completed transmit message. Four bits report live fill conditions of the 64-byte receive and transmit FIFOs. The top bit flags loss of carrier on the received line.

Carrier loss comes from a monitor that counts bit periods in which both received rails carry a zero. A one on either rail restarts the count. The loss threshold is 255 periods by default, and 2048 periods when a select input is high.

The host reads the word with a one-cycle read strobe. During that cycle the word is returned unchanged. The read then clears the sticky flags, but any event arriving in the same cycle is kept.

Top module: `hdlc_status_reg`

## Requirements
- R1: The status word bit positions are fixed: 7 carrier loss, 6 receive end, 5 receive start, 4 receive FIFO above half, 3 receive FIFO not empty, 2 transmit FIFO below half, 1 transmit FIFO has room, 0 transmit message done.
- R2: With `long_run_sel_i` low, bit 7 goes high in the cycle after the 255th consecutive bit-period strobe with both rails at zero. It is still low after the 254th.
- R3: With `long_run_sel_i` high, the same threshold is 2048 bit periods.
- R4: A strobed bit period with a one on either rail clears bit 7 in the next cycle and restarts the zero count. Cycles without `bit_en_i` do not count.
- R5: Bit 6 sets in the cycle after any of these pulses: good frame end, CRC error, FIFO overrun, or abort.
- R6: Bit 5 sets in the cycle after an opening-flag pulse.
- R7: Bit 0 sets in the cycle after a transmit-message-done pulse.
- R8: Bits 6, 5 and 0 stay set until a read. The read cycle returns them set, and they are clear in the following cycle.
- R9: An event pulse in the same cycle as a read leaves its bit set after the read.
- R10: Bit 4 is high while the receive fill exceeds 32. Bit 3 is high while the receive fill is nonzero.
- R11: Bit 2 is high while the transmit fill is below 32. Bit 1 is high while the transmit fill is below 64.
- R12: Reads have no effect on bits 7, 4, 3, 2 and 1.
- R13: Reset clears the sticky bits and the zero-run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| long_run_sel_i | input | 1 | Selects the 2048-period loss threshold |
| bit_en_i | input | 1 | Strobe marking one received bit period |
| rail_pos_i | input | 1 | Positive received rail |
| rail_neg_i | input | 1 | Negative received rail |
| rx_good_end_i | input | 1 | Frame ended with good CRC |
| rx_crc_err_i | input | 1 | Frame ended with CRC error |
| rx_overrun_i | input | 1 | Receive FIFO overrun |
| rx_abort_i | input | 1 | Abort sequence received |
| rx_open_flag_i | input | 1 | Opening flag detected |
| tx_msg_done_i | input | 1 | Transmitter finished a message |
| rx_fill_i | input | 7 | Receive FIFO fill, 0 to 64 |
| tx_fill_i | input | 7 | Transmit FIFO fill, 0 to 64 |
| rd_en_i | input | 1 | Host read strobe |
| status_o | output | 8 | Status word |

## Verification
The bench builds the block with its defaults: a 64-byte FIFO and thresholds of 255 and 2048. At these values, a full 2048-period zero run takes only a few thousand cycles, so the bench drives both thresholds exactly at their edges. The fill inputs cover every value from empty to full, so the boundaries at 0, 32, 33 and 64 are all reached under random stimulus.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int BIT_LOSS     = 7;
  localparam int BIT_RX_END   = 6;
  localparam int BIT_RX_START = 5;
  localparam int BIT_RX_HALF  = 4;
  localparam int BIT_RX_AVAIL = 3;
  localparam int BIT_TX_HALF  = 2;
  localparam int BIT_TX_ROOM  = 1;
  localparam int BIT_TX_DONE  = 0;
  localparam int NUM_STICKY   = 3;
  // sticky vector index order
  localparam int STK_TX_DONE  = 0;
  localparam int STK_RX_START = 1;
  localparam int STK_RX_END   = 2;
endpackage

// File: rtl/zero_run_mon.sv
module zero_run_mon #(
  parameter int SHORT_RUN = 255,
  parameter int LONG_RUN  = 2048,
  localparam int CW = $clog2(LONG_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_sel_i,
  input  logic bit_en_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic loss_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;

  assign thr = long_sel_i ? CW'(LONG_RUN) : CW'(SHORT_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_en_i) begin
      if (pos_i || neg_i) cnt_q <= '0;
      else if (cnt_q < thr) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign loss_o = (cnt_q >= thr);
endmodule

// File: rtl/sticky_events.sv
module sticky_events #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= ev_i[i] | (q_o[i] & ~clr_i);  // event wins over clear
    end
  end
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH = 64,
  localparam int FW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic [FW-1:0] rx_fill_i,
  input  logic [FW-1:0] tx_fill_i,
  output logic          rx_half_o,
  output logic          rx_avail_o,
  output logic          tx_half_o,
  output logic          tx_room_o
);
  assign rx_half_o  = rx_fill_i > FW'(HALF);
  assign rx_avail_o = rx_fill_i != '0;
  assign tx_half_o  = tx_fill_i < FW'(HALF);
  assign tx_room_o  = tx_fill_i < FW'(DEPTH);
endmodule

// File: rtl/hdlc_status_reg.sv
module hdlc_status_reg #(
  parameter int DEPTH     = 64,
  parameter int SHORT_RUN = 255,
  parameter int LONG_RUN  = 2048,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          long_run_sel_i,
  input  logic          bit_en_i,
  input  logic          rail_pos_i,
  input  logic          rail_neg_i,
  input  logic          rx_good_end_i,
  input  logic          rx_crc_err_i,
  input  logic          rx_overrun_i,
  input  logic          rx_abort_i,
  input  logic          rx_open_flag_i,
  input  logic          tx_msg_done_i,
  input  logic [FW-1:0] rx_fill_i,
  input  logic [FW-1:0] tx_fill_i,
  input  logic          rd_en_i,
  output logic [7:0]    status_o
);
  import hsr_pkg::*;

  logic                  loss;
  logic                  rx_half, rx_avail, tx_half, tx_room;
  logic [NUM_STICKY-1:0] ev, stk;

  zero_run_mon #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_zrun (
    .clk_i, .rst_ni,
    .long_sel_i(long_run_sel_i),
    .bit_en_i,
    .pos_i(rail_pos_i),
    .neg_i(rail_neg_i),
    .loss_o(loss)
  );

  always_comb begin
    ev               = '0;
    ev[STK_RX_END]   = rx_good_end_i | rx_crc_err_i | rx_overrun_i | rx_abort_i;
    ev[STK_RX_START] = rx_open_flag_i;
    ev[STK_TX_DONE]  = tx_msg_done_i;
  end

  sticky_events #(.N(NUM_STICKY)) u_stk (
    .clk_i, .rst_ni,
    .ev_i(ev),
    .clr_i(rd_en_i),
    .q_o(stk)
  );

  fifo_level_flags #(.DEPTH(DEPTH)) u_lvl (
    .rx_fill_i, .tx_fill_i,
    .rx_half_o(rx_half),
    .rx_avail_o(rx_avail),
    .tx_half_o(tx_half),
    .tx_room_o(tx_room)
  );

  always_comb begin
    status_o               = '0;
    status_o[BIT_LOSS]     = loss;
    status_o[BIT_RX_END]   = stk[STK_RX_END];
    status_o[BIT_RX_START] = stk[STK_RX_START];
    status_o[BIT_RX_HALF]  = rx_half;
    status_o[BIT_RX_AVAIL] = rx_avail;
    status_o[BIT_TX_HALF]  = tx_half;
    status_o[BIT_TX_ROOM]  = tx_room;
    status_o[BIT_TX_DONE]  = stk[STK_TX_DONE];
  end
endmodule

// File: rtl/hdlc_status_chk.sv
module hdlc_status_chk #(
  parameter int FW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          long_run_sel_i,
  input logic          bit_en_i,
  input logic          rail_pos_i,
  input logic          rail_neg_i,
  input logic          rx_good_end_i,
  input logic          rx_crc_err_i,
  input logic          rx_overrun_i,
  input logic          rx_abort_i,
  input logic          rx_open_flag_i,
  input logic          tx_msg_done_i,
  input logic [FW-1:0] rx_fill_i,
  input logic [FW-1:0] tx_fill_i,
  input logic          rd_en_i,
  input logic [7:0]    status_o
);
  import hsr_pkg::*;

  AST_RX_END_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_good_end_i || rx_crc_err_i || rx_overrun_i || rx_abort_i) |=> status_o[BIT_RX_END]); // R5
  AST_RX_START_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_open_flag_i |=> status_o[BIT_RX_START]); // R6
  AST_TX_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_msg_done_i |=> status_o[BIT_TX_DONE]); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BIT_RX_START] && !rd_en_i) |=> status_o[BIT_RX_START]); // R8
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !tx_msg_done_i) |=> !status_o[BIT_TX_DONE]); // R8
  AST_EVENT_BEATS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rx_open_flag_i) |=> status_o[BIT_RX_START]); // R9
  AST_MARK_DROPS_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && (rail_pos_i || rail_neg_i)) |=> !status_o[BIT_LOSS]); // R4
  AST_LOSS_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[BIT_LOSS]) && $stable(long_run_sel_i)) |->
      $past(bit_en_i && !rail_pos_i && !rail_neg_i)); // R2
  AST_RX_LEVEL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[BIT_RX_HALF] |-> status_o[BIT_RX_AVAIL]); // R10
  AST_TX_LEVEL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[BIT_TX_HALF] |-> status_o[BIT_TX_ROOM]); // R11
endmodule

bind hdlc_status_reg hdlc_status_chk #(.FW(FW)) u_chk (
  .clk_i, .rst_ni, .long_run_sel_i, .bit_en_i, .rail_pos_i, .rail_neg_i,
  .rx_good_end_i, .rx_crc_err_i, .rx_overrun_i, .rx_abort_i,
  .rx_open_flag_i, .tx_msg_done_i, .rx_fill_i, .tx_fill_i, .rd_en_i, .status_o
);

// File: tb/tb_hdlc_status_reg.sv
`timescale 1ns/1ps
module tb_hdlc_status_reg;
  localparam int FW = 7;

  logic clk = 0, rst_ni = 0;
  logic long_run_sel_i = 0, bit_en_i = 0, rail_pos_i = 0, rail_neg_i = 0;
  logic rx_good_end_i = 0, rx_crc_err_i = 0, rx_overrun_i = 0, rx_abort_i = 0;
  logic rx_open_flag_i = 0, tx_msg_done_i = 0, rd_en_i = 0;
  logic [FW-1:0] rx_fill_i = 0, tx_fill_i = 0;
  logic [7:0] status_o;

  int n_chk = 0, n_bad = 0;
  int zc_m = 0;
  logic [2:0] stk_m = 0;  // {rx_end, rx_start, tx_done}

  always #2.5 clk = ~clk;

  hdlc_status_reg dut (
    .clk_i(clk), .rst_ni, .long_run_sel_i, .bit_en_i, .rail_pos_i, .rail_neg_i,
    .rx_good_end_i, .rx_crc_err_i, .rx_overrun_i, .rx_abort_i, .rx_open_flag_i,
    .tx_msg_done_i, .rx_fill_i, .tx_fill_i, .rd_en_i, .status_o
  );

  function automatic int thr_m();
    return long_run_sel_i ? 2048 : 255;
  endfunction

  function automatic logic [7:0] exp_status();
    return {zc_m >= thr_m(), stk_m[2], stk_m[1], rx_fill_i > 32, rx_fill_i != 0,
            tx_fill_i < 32, tx_fill_i < 64, stk_m[0]};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: status act=%02h exp=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_pulses();
    rx_good_end_i = 0; rx_crc_err_i = 0; rx_overrun_i = 0; rx_abort_i = 0;
    rx_open_flag_i = 0; tx_msg_done_i = 0; rd_en_i = 0;
    bit_en_i = 0; rail_pos_i = 0; rail_neg_i = 0;
  endtask

  // compare the current word, then clock once and update the model
  task automatic cycle(string tag);
    #1 check(tag, status_o, exp_status());
    @(posedge clk);
    if (bit_en_i) begin
      if (rail_pos_i || rail_neg_i) zc_m = 0;
      else if (zc_m < thr_m()) zc_m++;
    end
    stk_m[2] = (rx_good_end_i | rx_crc_err_i | rx_overrun_i | rx_abort_i) | (stk_m[2] & ~rd_en_i);
    stk_m[1] = rx_open_flag_i | (stk_m[1] & ~rd_en_i);
    stk_m[0] = tx_msg_done_i | (stk_m[0] & ~rd_en_i);
    #1 clear_pulses();
  endtask

  task automatic zero_periods(int n);
    for (int i = 0; i < n; i++) begin
      bit_en_i = 1;
      cycle("R2");
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // assert reset with pending activity on the inputs
    bit_en_i = 1; tx_msg_done_i = 1;
    repeat (3) @(posedge clk);
    #1 clear_pulses();
    rst_ni = 1;
    cycle("R13");
    check("R13", status_o, 8'h06);

    // R1 layout
    rx_fill_i = 40; tx_fill_i = 64; rx_open_flag_i = 1;
    cycle("R6");
    #1 check("R1", status_o, 8'h38);
    rd_en_i = 1;
    cycle("R8");
    cycle("R8");

    // R2: threshold 255
    rx_fill_i = 0; tx_fill_i = 10;
    zero_periods(254);
    #1 check("R2", status_o & 8'h80, 8'h00);
    cycle("R4");  // idle cycle without strobe must not count
    #1 check("R4", status_o & 8'h80, 8'h00);
    zero_periods(1);
    #1 check("R2", status_o & 8'h80, 8'h80);
    zero_periods(5);  // saturates
    // R12: a read leaves the loss and level bits alone
    rd_en_i = 1; rx_fill_i = 33;
    cycle("R12");
    #1 check("R12", status_o, 8'h9E);
    // R4: a mark on the negative rail
    bit_en_i = 1; rail_neg_i = 1;
    cycle("R4");
    #1 check("R4", status_o & 8'h80, 8'h00);

    // R3: threshold 2048
    long_run_sel_i = 1;
    zero_periods(2047);
    #1 check("R3", status_o & 8'h80, 8'h00);
    zero_periods(1);
    #1 check("R3", status_o & 8'h80, 8'h80);
    bit_en_i = 1; rail_pos_i = 1;
    cycle("R4");
    long_run_sel_i = 0;

    // R5: each fault source
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: rx_good_end_i = 1;
        1: rx_crc_err_i = 1;
        2: rx_overrun_i = 1;
        default: rx_abort_i = 1;
      endcase
      cycle("R5");
      #1 check("R5", status_o & 8'h40, 8'h40);
      rd_en_i = 1;
      cycle("R8");
      #1 check("R8", status_o & 8'h40, 8'h00);
    end

    // R7 and R9
    tx_msg_done_i = 1;
    cycle("R7");
    #1 check("R7", status_o & 8'h01, 8'h01);
    rd_en_i = 1; tx_msg_done_i = 1;
    cycle("R9");
    #1 check("R9", status_o & 8'h01, 8'h01);
    rd_en_i = 1;
    cycle("R8");

    // R10/R11 boundary fills
    for (int f = 0; f <= 64; f++) begin
      rx_fill_i = f[FW-1:0]; tx_fill_i = 7'(64 - f);
      cycle("R10");
    end

    // random mix
    for (int i = 0; i < 6000; i++) begin
      rx_fill_i = 7'($urandom_range(0, 64));
      tx_fill_i = 7'($urandom_range(0, 64));
      bit_en_i = ($urandom_range(0, 1) == 1);
      rail_pos_i = ($urandom_range(0, 399) == 0);
      rail_neg_i = ($urandom_range(0, 399) == 0);
      rx_good_end_i = ($urandom_range(0, 15) == 0);
      rx_crc_err_i = ($urandom_range(0, 31) == 0);
      rx_overrun_i = ($urandom_range(0, 31) == 0);
      rx_abort_i = ($urandom_range(0, 31) == 0);
      rx_open_flag_i = ($urandom_range(0, 9) == 0);
      tx_msg_done_i = ($urandom_range(0, 9) == 0);
      rd_en_i = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 999) == 0) long_run_sel_i = ~long_run_sel_i;
      cycle("R11");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule